// File: doc/BRIEF.md
# Boot-Chip Immediate Access Responder

This block sits on the device side of one expansion channel and answers the word-at-a-time (immediate) protocol of a boot and clock companion chip. After the channel selects the device, the first immediate write is taken as a command address. Every later immediate access then reads or writes the resource mapped at that address. The mapped resources are a 32-bit seconds counter, a small battery-backed parameter RAM and a debug UART output.

Addresses are held pre-shifted left by six. A parameter-RAM access moves the held address forward by its byte count shifted left by six, so a host can stream through the RAM with back-to-back accesses. A command word below 0x20000000 is shifted right by six when it is captured. Every access ends with a one-cycle `done_o` pulse. A UART write ends only after its last byte has been handed off on the valid/ready byte stream.

Top module: `bootchip_responder`

## Requirements
- R1: After reset `rdata_o` is 0, `done_o`, `err_o` and `uart_valid_o` are low, and the next write accepted while selected is taken as a command address.
- R2: An access is accepted when `start_i` is high, `sel_i` is high and no UART write is in progress. Its `done_o` pulse comes one cycle later. While `sel_i` is low a start has no effect, and the next accepted write becomes the command address again. A captured word below 0x20000000 is stored shifted right by 6; any other word is stored unchanged.
- R3: Address decoding ignores bit 31 of the held address.
- R4: A read at 0x20000000 returns the seconds counter. The counter adds 1 on each cycle with `tick_i` high. `rtc_load_i` presets it to `rtc_load_val_i` and takes priority over a tick.
- R5: A read at an address in [0x20000100, 0x20001100) returns len_i+1 bytes from the parameter RAM. The start offset is (addr[11:6] − 4) mod 64 and later bytes wrap modulo 64. The byte at the start offset lands in bits [31:24], the following bytes land in lower lanes, and unused low lanes read 0.
- R6: A write at an address in [0x20000100, 0x20001000] stores len_i+1 bytes at the same offset rule. Bits [31:24] go to the start offset and lower lanes go to the following offsets.
- R7: Each parameter-RAM access advances the held address by (len_i+1)<<6. No other access changes it.
- R8: A read at 0x20010000 returns 0x03000000.
- R9: A write at an address in [0x20010000, 0x200100FF] sends len_i+1 bytes on `uart_data_o`, most significant lane first, one per accepted valid/ready handshake. The data stays stable while a byte is stalled. `done_o` pulses in the cycle after the last byte is accepted, and starts issued meanwhile are ignored.
- R10: Any other access completes with `done_o` and `err_o` both high, with `rdata_o` cleared to 0. It leaves the held address and the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Device select from the channel |
| start_i | input | 1 | Start one immediate access |
| wr_i | input | 1 | 1 = write, 0 = read |
| len_i | input | 2 | Transfer length minus one, in bytes |
| wdata_i | input | 32 | Immediate write word |
| rdata_o | output | 32 | Immediate read word |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Access hit an unmapped address (with done) |
| tick_i | input | 1 | Seconds tick enable |
| rtc_load_i | input | 1 | Preset seconds counter |
| rtc_load_val_i | input | 32 | Preset value |
| uart_valid_o | output | 1 | UART byte valid |
| uart_data_o | output | 8 | UART byte |
| uart_ready_i | input | 1 | UART byte accepted |

## Verification
A wrong held address shows up as a wrong resource in the very next access. The symptoms are a wrong RAM byte, the status word where RAM data was expected, or a spurious `err_o` in the completion cycle. Streamed reads expose a wrong advance one access later. Offset-wrap and upper-bound errors surface as wrong bytes or a missing error at the RAM edges. A stuck or miscounted UART serializer shows at once as a missing, repeated or early `done_o`, or as a byte that changes while stalled.

// File: rtl/bootchip_pkg.sv
package bootchip_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LANES      = WORD_W / 8;
  localparam int unsigned LEN_W      = $clog2(LANES);
  localparam int unsigned ADDR_SHIFT = 6;

  localparam logic [WORD_W-1:0] CMD_SHIFT_LIMIT = 32'h2000_0000;
  localparam logic [WORD_W-1:0] RTC_ADDR        = 32'h2000_0000;
  localparam logic [WORD_W-1:0] PRAM_BASE       = 32'h2000_0100;
  localparam logic [WORD_W-1:0] PRAM_WR_LAST    = 32'h2000_1000;
  localparam logic [WORD_W-1:0] UART_BASE       = 32'h2001_0000;
  localparam logic [WORD_W-1:0] UART_STATUS     = 32'h0300_0000;

  typedef enum logic {ST_IDLE, ST_UART} resp_state_e;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_RTC, TGT_PRAM, TGT_USTAT, TGT_UTX
  } target_e;
endpackage

// File: rtl/bootchip_rtc.sv
module bootchip_rtc #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | tick_i;
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bootchip_pram.sv
module bootchip_pram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [8*LANES-1:0] wdata_i,
  output logic [8*LANES-1:0] rdata_o
);
  logic [7:0] mem [DEPTH];

  // lane k maps to byte idx+k (wrapping), lane 0 is the top byte of the word
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k <= int'(len_i))
        rdata_o[8*(LANES-k)-1 -: 8] = mem[idx_i + IDX_W'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k <= int'(len_i))
          mem[idx_i + IDX_W'(k)] <= wdata_i[8*(LANES-k)-1 -: 8];
      end
    end
  end
endmodule

// File: rtl/bootchip_uart_tx.sv
module bootchip_uart_tx #(
  parameter int unsigned LANES = 4,
  localparam int unsigned LEN_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [8*LANES-1:0] data_i,
  output logic               valid_o,
  output logic [7:0]         byte_o,
  input  logic               ready_i,
  output logic               last_o
);
  logic               busy_q, busy_d;
  logic [8*LANES-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      busy_d = 1'b1;
      sh_d   = data_i;
      cnt_d  = len_i;
    end else if (busy_q && ready_i) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - LEN_W'(1);
        sh_d  = sh_q << 8;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign valid_o = busy_q;
  assign byte_o  = sh_q[8*LANES-1 -: 8];
  assign last_o  = busy_q && ready_i && (cnt_q == '0);
endmodule

// File: rtl/bootchip_responder.sv
module bootchip_responder
  import bootchip_pkg::*;
#(
  parameter int unsigned PRAM_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  input  logic              tick_i,
  input  logic              rtc_load_i,
  input  logic [WORD_W-1:0] rtc_load_val_i,
  output logic              uart_valid_o,
  output logic [7:0]        uart_data_o,
  input  logic              uart_ready_i
);
  localparam int unsigned IDX_W = $clog2(PRAM_BYTES);
  localparam logic [WORD_W-1:0] PRAM_RD_END =
    PRAM_BASE + (WORD_W'(PRAM_BYTES) << ADDR_SHIFT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  resp_state_e       state_q, state_d;
  logic [WORD_W-1:0] addr_q, addr_d, rdata_q, rdata_d;
  logic              done_q, done_d, err_q, err_d, armed_q, armed_d;
  logic              accept, pram_we, utx_load, utx_last;
  logic [WORD_W-1:0] ofs, step, rtc_count, pram_rdata;
  logic [IDX_W-1:0]  pram_idx;
  target_e           tgt;

  bootchip_rtc #(.CNT_W(WORD_W)) u_rtc (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i), .load_i(rtc_load_i),
    .load_val_i(rtc_load_val_i), .count_o(rtc_count)
  );

  bootchip_pram #(.DEPTH(PRAM_BYTES), .LANES(LANES)) u_pram (
    .clk(clk), .we_i(pram_we), .idx_i(pram_idx), .len_i(len_i),
    .wdata_i(wdata_i), .rdata_o(pram_rdata)
  );

  bootchip_uart_tx #(.LANES(LANES)) u_utx (
    .clk(clk), .rst_n(rst_int_n), .load_i(utx_load), .len_i(len_i),
    .data_i(wdata_i), .valid_o(uart_valid_o), .byte_o(uart_data_o),
    .ready_i(uart_ready_i), .last_o(utx_last)
  );

  // address decode on the held address with bit 31 cleared
  always_comb begin
    ofs      = addr_q & 32'h7FFF_FFFF;
    pram_idx = ofs[ADDR_SHIFT +: IDX_W] - IDX_W'(4);
    step     = (WORD_W'(len_i) + WORD_W'(1)) << ADDR_SHIFT;
    tgt      = TGT_NONE;
    if (wr_i) begin
      if (ofs >= PRAM_BASE && ofs <= PRAM_WR_LAST)  tgt = TGT_PRAM;
      else if (ofs[WORD_W-1:8] == UART_BASE[WORD_W-1:8]) tgt = TGT_UTX;
    end else begin
      if (ofs == RTC_ADDR)                          tgt = TGT_RTC;
      else if (ofs >= PRAM_BASE && ofs < PRAM_RD_END) tgt = TGT_PRAM;
      else if (ofs == UART_BASE)                    tgt = TGT_USTAT;
    end
  end

  assign accept = start_i && sel_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rdata_d  = rdata_q;
    armed_d  = armed_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    pram_we  = 1'b0;
    utx_load = 1'b0;
    if (!sel_i) armed_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (accept && wr_i && armed_q) begin
          addr_d  = (wdata_i < CMD_SHIFT_LIMIT) ? (wdata_i >> ADDR_SHIFT) : wdata_i;
          armed_d = 1'b0;
          done_d  = 1'b1;
        end else if (accept) begin
          case (tgt)
            TGT_RTC: begin
              rdata_d = rtc_count;
              done_d  = 1'b1;
            end
            TGT_PRAM: begin
              if (wr_i) pram_we = 1'b1;
              else      rdata_d = pram_rdata;
              addr_d = addr_q + step;
              done_d = 1'b1;
            end
            TGT_USTAT: begin
              rdata_d = UART_STATUS;
              done_d  = 1'b1;
            end
            TGT_UTX: begin
              utx_load = 1'b1;
              state_d  = ST_UART;
            end
            default: begin
              rdata_d = '0;
              err_d   = 1'b1;
              done_d  = 1'b1;
            end
          endcase
        end
      end
      ST_UART: begin
        if (utx_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
      armed_q <= armed_d;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bootchip_responder_chk.sv
module bootchip_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_i,
  input logic        start_i,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] rdata_o,
  input logic        uart_valid_o,
  input logic [7:0]  uart_data_o,
  input logic        uart_ready_i,
  input logic        tick_i,
  input logic        rtc_load_i,
  input logic [31:0] rtc_load_val_i,
  input logic [31:0] rtc_count
);
  p_err_has_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rdata_o == 32'h0));

  p_uart_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_valid_o && !uart_ready_i) |=> (uart_valid_o && $stable(uart_data_o)));

  p_no_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uart_valid_o |-> !done_o);

  p_rtc_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !rtc_load_i) |=> (rtc_count == $past(rtc_count) + 32'd1));

  p_rtc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_load_i |=> (rtc_count == $past(rtc_load_val_i)));

  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(start_i && sel_i) || $past(uart_valid_o && uart_ready_i)));

  p_unselected_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && !uart_valid_o) |=> !done_o);
endmodule

bind bootchip_responder bootchip_responder_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .sel_i(sel_i), .start_i(start_i),
  .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .uart_valid_o(uart_valid_o), .uart_data_o(uart_data_o),
  .uart_ready_i(uart_ready_i), .tick_i(tick_i), .rtc_load_i(rtc_load_i),
  .rtc_load_val_i(rtc_load_val_i), .rtc_count(rtc_count)
);

// File: tb/bootchip_responder_tb_top.sv
module bootchip_responder_tb_top;
  localparam int CLK_P = 10;

  logic        clk, rst_n, sel_i, start_i, wr_i, tick_i, rtc_load_i, uart_ready_i;
  logic [1:0]  len_i;
  logic [31:0] wdata_i, rtc_load_val_i, rdata_o;
  logic        done_o, err_o, uart_valid_o;
  logic [7:0]  uart_data_o;

  int n_chk = 0;
  int n_fail = 0;

  bootchip_responder dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .start_i(start_i), .wr_i(wr_i),
    .len_i(len_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
    .err_o(err_o), .tick_i(tick_i), .rtc_load_i(rtc_load_i),
    .rtc_load_val_i(rtc_load_val_i), .uart_valid_o(uart_valid_o),
    .uart_data_o(uart_data_o), .uart_ready_i(uart_ready_i)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic reselect();
    @(negedge clk) sel_i = 1'b0;
    @(negedge clk) sel_i = 1'b1;
  endtask

  // one access; outputs sampled at the negedge after the accepting edge
  task automatic access(input logic w, input logic [1:0] l, input logic [31:0] d,
                        output logic dn, output logic er, output logic [31:0] rd);
    @(negedge clk);
    start_i = 1'b1; wr_i = w; len_i = l; wdata_i = d;
    @(negedge clk);
    start_i = 1'b0;
    dn = done_o; er = err_o; rd = rdata_o;
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 reselect, 1 write, 2 read
    logic [1:0]  len;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},  // R2 reselect
    '{2'd1, 2'd0, 32'h2000_0100, 32'h0,         1'b0, 4'd2},  // R2 capture
    '{2'd1, 2'd3, 32'h1122_3344, 32'h0,         1'b0, 4'd6},  // R6 bytes 0..3
    '{2'd1, 2'd1, 32'hAABB_0000, 32'h0,         1'b0, 4'd7},  // R7 bytes 4..5
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_0100, 32'h0,         1'b0, 4'd2},
    '{2'd2, 2'd3, 32'h0,         32'h1122_3344, 1'b0, 4'd5},  // R5
    '{2'd2, 2'd0, 32'h0,         32'hAA00_0000, 1'b0, 4'd7},  // R7 advanced
    '{2'd2, 2'd0, 32'h0,         32'hBB00_0000, 1'b0, 4'd7},
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'hA000_0140, 32'h0,         1'b0, 4'd3},  // R3 bit 31
    '{2'd2, 2'd1, 32'h0,         32'h2233_0000, 1'b0, 4'd3},
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_1000, 32'h0,         1'b0, 4'd6},  // offset 60
    '{2'd1, 2'd3, 32'hC0C1_C2C3, 32'h0,         1'b0, 4'd6},  // last write addr
    '{2'd1, 2'd0, 32'h5500_0000, 32'h0,         1'b1, 4'd6},  // R6 past bound
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_1080, 32'h0,         1'b0, 4'd5},  // offset 62
    '{2'd2, 2'd3, 32'h0,         32'hC2C3_1122, 1'b0, 4'd5},  // R5 wrap
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_1040, 32'h0,         1'b0, 4'd6},  // offset 61
    '{2'd1, 2'd0, 32'h7700_0000, 32'h0,         1'b1, 4'd10}, // R10 write refused
    '{2'd2, 2'd0, 32'h0,         32'hC100_0000, 1'b0, 4'd10}, // R10 RAM intact
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2001_0000, 32'h0,         1'b0, 4'd8},
    '{2'd2, 2'd3, 32'h0,         32'h0300_0000, 1'b0, 4'd8},  // R8
    '{2'd2, 2'd0, 32'h0,         32'h0300_0000, 1'b0, 4'd7},  // R7 no advance
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_0000, 32'h0,         1'b0, 4'd4},
    '{2'd2, 2'd3, 32'h0,         32'h1234_5678, 1'b0, 4'd4},  // R4
    '{2'd1, 2'd3, 32'h0,         32'h0,         1'b1, 4'd10}, // R10 write at clock
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h1FFF_FFC0, 32'h0,         1'b0, 4'd2},  // R2 shifted
    '{2'd2, 2'd3, 32'h0,         32'h0,         1'b1, 4'd2},
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2000_0040, 32'h0,         1'b0, 4'd10},
    '{2'd2, 2'd0, 32'h0,         32'h0,         1'b1, 4'd10}, // R10 unmapped
    '{2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 4'd2},
    '{2'd1, 2'd0, 32'h2001_0004, 32'h0,         1'b0, 4'd10},
    '{2'd2, 2'd0, 32'h0,         32'h0,         1'b1, 4'd10}
  };

  initial begin
    #(CLK_P*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic dn, er;
    logic [31:0] rd;
    rst_n = 1'b0; sel_i = 1'b1; start_i = 1'b0; wr_i = 1'b0; len_i = '0;
    wdata_i = '0; tick_i = 1'b0; rtc_load_i = 1'b0; rtc_load_val_i = '0;
    uart_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(rdata_o == 32'h0, "R1 rdata", rdata_o, 32'h0);
    check({done_o, err_o, uart_valid_o} == 3'b000, "R1 flags",
          {29'h0, done_o, err_o, uart_valid_o}, 32'h0);
    // R1 armed from reset: first write is a command address
    access(1'b1, 2'd0, 32'h2001_0000, dn, er, rd);
    check(dn && !er, "R1 capture done", {30'h0, dn, er}, 32'h2);
    access(1'b0, 2'd3, 32'h0, dn, er, rd);
    check(rd == 32'h0300_0000, "R1 armed at reset", rd, 32'h0300_0000);

    // R2 start ignored while deselected
    @(negedge clk) sel_i = 1'b0;
    access(1'b0, 2'd0, 32'h0, dn, er, rd);
    check(!dn, "R2 start while deselected", {31'h0, dn}, 32'h0);
    @(negedge clk) sel_i = 1'b1;

    @(negedge clk) begin rtc_load_i = 1'b1; rtc_load_val_i = 32'h1234_5678; end
    @(negedge clk) rtc_load_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].kind == 2'd0) begin
        reselect();
      end else begin
        access(VEC[i].kind == 2'd1, VEC[i].len, VEC[i].data, dn, er, rd);
        check(dn == 1'b1, $sformatf("R%0d done row %0d", VEC[i].req, i),
              {31'h0, dn}, 32'h1);
        check(er == VEC[i].exp_err, $sformatf("R%0d err row %0d", VEC[i].req, i),
              {31'h0, er}, {31'h0, VEC[i].exp_err});
        if (VEC[i].kind == 2'd2)
          check(rd === VEC[i].exp, $sformatf("R%0d data row %0d", VEC[i].req, i),
                rd, VEC[i].exp);
      end
    end

    // R4 ticks, load priority, wrap
    reselect();
    access(1'b1, 2'd0, 32'h2000_0000, dn, er, rd);
    repeat (3) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
    access(1'b0, 2'd3, 32'h0, dn, er, rd);
    check(rd == 32'h1234_567B, "R4 three ticks", rd, 32'h1234_567B);
    @(negedge clk) begin rtc_load_i = 1'b1; tick_i = 1'b1; rtc_load_val_i = 32'hFFFF_FFFF; end
    @(negedge clk) begin rtc_load_i = 1'b0; tick_i = 1'b0; end
    access(1'b0, 2'd3, 32'h0, dn, er, rd);
    check(rd == 32'hFFFF_FFFF, "R4 load beats tick", rd, 32'hFFFF_FFFF);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    access(1'b0, 2'd3, 32'h0, dn, er, rd);
    check(rd == 32'h0, "R4 wrap", rd, 32'h0);

    // R9 UART stream with stalls and a start while busy
    reselect();
    access(1'b1, 2'd0, 32'h2001_0010, dn, er, rd);
    access(1'b1, 2'd2, 32'hDEAD_BE00, dn, er, rd);
    check(!dn, "R9 no early done", {31'h0, dn}, 32'h0);
    begin
      logic [7:0] got [4];
      logic [7:0] prev_b;
      int ng = 0, nd = 0, last_acc = -10, done_cyc = -1;
      bit prev_stall = 0;
      prev_b = '0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (done_o) begin nd++; done_cyc = c; end
        start_i = (c == 2); wr_i = 1'b1; len_i = 2'd0; wdata_i = 32'h9900_0000;
        if (uart_valid_o) begin
          if (prev_stall)
            check(uart_data_o == prev_b, "R9 stable while stalled",
                  {24'h0, uart_data_o}, {24'h0, prev_b});
          if (c % 2 == 1) begin
            uart_ready_i = 1'b1;
            if (ng < 4) got[ng] = uart_data_o;
            ng++; last_acc = c; prev_stall = 0;
          end else begin
            uart_ready_i = 1'b0; prev_stall = 1; prev_b = uart_data_o;
          end
        end else begin
          uart_ready_i = 1'b0; prev_stall = 0;
        end
      end
      start_i = 1'b0;
      check(ng == 3, "R9 byte count", ng, 3);
      check(got[0] == 8'hDE && got[1] == 8'hAD && got[2] == 8'hBE, "R9 byte order",
            {got[0], got[1], got[2], 8'h0}, 32'hDEADBE00);
      check(nd == 1, "R9 single done", nd, 1);
      check(done_cyc == last_acc + 1, "R9 done after last byte", done_cyc, last_acc + 1);
      check(!uart_valid_o, "R9 idle after", {31'h0, uart_valid_o}, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule